// File: doc/BRIEF.md
# Serial Memory Read Target

This block is a two-wire bus target that presents a 4096-byte memory to a bus master for reading. It watches oversampled clock and data levels from open-drain pads. It pulls the data line low through a single drive-low output and never drives it high. The block keeps a 12-bit word pointer that carries over from one transaction to the next. With this pointer the master can do three kinds of read:

- a read from wherever the pointer already sits;
- a read at an arbitrary location, set by a short write-type transfer that carries only the location and then a repeated Start;
- a streamed run of bytes that goes on for as long as the master keeps acknowledging.

The array cannot be programmed over the bus. At reset it is filled with a fixed pattern that is computed from each byte's location. A system level therefore knows every byte it should read back. The block answers only to control bytes whose device-type nibble and three chip-select bits match. The chip-select bits come from a static strap input.

Top module: `eeprom_read_target`

## Requirements
- R1: After reset the data line is released and the word pointer is 0x000.
- R2: A control byte is bits[7:4] = 4'b1010, bits[3:1] equal to `strapSel`, and bit[0] = R/W (1 = read, 0 = write-type), sent MSB first. The target pulls the data line low during the acknowledge clock that follows a matching control byte.
- R3: If the device-type nibble or the chip-select bits do not match, the target gives no acknowledge. It keeps the line released for the rest of the transaction, up to the next Start, and its word pointer is left unchanged.
- R4: After a matching read control byte, the target sends the byte stored at the word pointer, MSB first. Data changes only while the clock is low.
- R5: A write-type control byte is followed by two location bytes, high byte first. The target acknowledges each of them. Only bits[3:0] of the high byte are used. The pointer is loaded once the low byte is complete, and the array is never modified.
- R6: When the master acknowledges a byte, the target sends the next byte in sequence.
- R7: When the master acknowledges the byte at 0xFFF, the byte sent next is the one at 0x000.
- R8: When the master does not acknowledge a byte and then sends Stop, the target releases the line. The pointer then holds the location just past the last byte sent.
- R9: The drive-low output never changes while the bus clock is high.
- R10: At reset the byte at location a is loaded as (a[7:0]) XOR ({a[11:8], a[11:8]}) XOR 8'h5A.
- R11: A Start or Stop in the middle of a byte ends the transfer that was in progress. After a Start the target decodes a new control byte. The pointer stays untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low reset; also refills the array |
| sclIn | input | 1 | Bus clock level from the pad |
| sdaIn | input | 1 | Bus data level from the pad |
| strapSel | input | 3 | Static chip-select code that the control byte must match |
| sdaDriveLow | output | 1 | High to pull the data line low |

## Verification
The bench goes after the pointer corners:
- A streamed read across 0xFFF checks the wrap. A design that wrapped at the wrong moment, or saturated there, would return wrong bytes after 0xFFF.
- Reads from the current location taken just after random and streamed reads would show a pointer that was left on the last byte instead of one past it.
- The high location byte carries junk in its upper nibble. A design that used those bits would read from the wrong place.

Control bytes with a wrong chip-select code and with a wrong device nibble must get no acknowledge and no drive at all. A target that responded anyway would pull the line low while the master clocks. A Start placed inside a location byte, and a Stop placed inside a control byte, must leave the pointer unchanged. An engine that failed to abort would load a half-built location or lose the decode of the next control byte.

// File: rtl/eeprd_pkg.sv
package eeprd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_MACK,
    ST_NEXT,
    ST_IGN
  } state_t;

  typedef enum logic [1:0] {
    RK_CTRL,
    RK_AHI,
    RK_ALO
  } rxKind_t;

  // one-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic rxShift;
    logic latchHi;
    logic latchLo;
    logic txLoad;
    logic txShift;
    logic ptrInc;
    logic ackOn;
    logic relOn;
  } strobe_t;

endpackage

// File: rtl/eeprd_busmon.sv
module eeprd_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclSh;
  logic [SYNC_STAGES-1:0] sdaSh;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl   = sclSh[SYNC_STAGES-1];
  assign sdaLvl   = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/eeprd_ctrl.sv
module eeprd_ctrl
  import eeprd_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclRise,
  input  logic            sclFall,
  input  logic            startDet,
  input  logic            stopDet,
  input  logic            sdaLvl,
  input  logic [7:0]      rxByte,
  input  logic [2:0]      strapSel,
  output strobe_t         strb,
  output state_t          stateOut
);

  state_t    state, stateNxt;
  rxKind_t   kind, kindNxt;
  logic      rdReq, rdNxt;
  logic [3:0] bitCnt, cntNxt;
  logic      ctrlHit;

  assign ctrlHit  = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == strapSel);
  assign stateOut = state;

  always_comb begin
    stateNxt = state;
    kindNxt  = kind;
    rdNxt    = rdReq;
    cntNxt   = bitCnt;
    strb     = '0;
    if (stopDet) begin
      stateNxt   = ST_IDLE;
      strb.relOn = 1'b1;
    end else if (startDet) begin
      stateNxt   = ST_RX;
      kindNxt    = RK_CTRL;
      cntNxt     = 4'd0;
      strb.relOn = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            strb.rxShift = 1'b1;
            cntNxt       = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (kind == RK_CTRL) begin
              if (ctrlHit) begin
                strb.ackOn = 1'b1;
                rdNxt      = rxByte[0];
                stateNxt   = ST_RXACK;
              end else begin
                stateNxt = ST_IGN;
              end
            end else begin
              strb.ackOn   = 1'b1;
              strb.latchHi = (kind == RK_AHI);
              strb.latchLo = (kind == RK_ALO);
              stateNxt     = ST_RXACK;
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            cntNxt = 4'd0;
            if (kind == RK_CTRL && rdReq) begin
              strb.txLoad = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              strb.relOn = 1'b1;
              if (kind == RK_CTRL) begin
                kindNxt  = RK_AHI;
                stateNxt = ST_RX;
              end else if (kind == RK_AHI) begin
                kindNxt  = RK_ALO;
                stateNxt = ST_RX;
              end else begin
                stateNxt = ST_IGN;
              end
            end
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt < 4'd8) begin
            cntNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              strb.relOn = 1'b1;
              stateNxt   = ST_MACK;
            end else begin
              strb.txShift = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            strb.ptrInc = 1'b1;
            stateNxt    = sdaLvl ? ST_IGN : ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (sclFall) begin
            strb.txLoad = 1'b1;
            cntNxt      = 4'd0;
            stateNxt    = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= RK_CTRL;
      rdReq  <= 1'b0;
      bitCnt <= 4'd0;
    end else begin
      state  <= stateNxt;
      kind   <= kindNxt;
      rdReq  <= rdNxt;
      bitCnt <= cntNxt;
    end
  end

  // R2
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RXACK) |-> (bitCnt == 4'd8));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_RX && bitCnt == 4'd0 && kind == RK_CTRL));

endmodule

// File: rtl/eeprd_dpath.sv
module eeprd_dpath
  import eeprd_pkg::*;
#(
  parameter int         ADDR_W       = 12,
  parameter logic [7:0] PRELOAD_SEED = 8'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       sdaLvl,
  input  logic       sclLvl,
  output logic [7:0] rxByte,
  output logic       sdaLow
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HI_BITS = ADDR_W - 8;

  logic [7:0]         mem [DEPTH];
  logic [ADDR_W-1:0]  ptr;
  logic [HI_BITS-1:0] hiReg;
  logic [7:0]         txReg;
  logic [7:0]         rdByte;

  function automatic logic [7:0] preByte(input logic [ADDR_W-1:0] a);
    logic [7:0] hi8;
    hi8 = 8'(a >> 8);
    return a[7:0] ^ 8'(hi8 * 8'h11) ^ PRELOAD_SEED;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= preByte(ADDR_W'(i));
    end
  end

  assign rdByte = mem[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= 8'd0;
      hiReg  <= '0;
      ptr    <= '0;
    end else begin
      if (strb.rxShift) rxByte <= {rxByte[6:0], sdaLvl};
      if (strb.latchHi) hiReg <= rxByte[HI_BITS-1:0];
      if (strb.latchLo) ptr <= {hiReg, rxByte};
      else if (strb.ptrInc) ptr <= ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= 8'd0;
      sdaLow <= 1'b0;
    end else if (strb.relOn) begin
      sdaLow <= 1'b0;
    end else if (strb.ackOn) begin
      sdaLow <= 1'b1;
    end else if (strb.txLoad) begin
      txReg  <= rdByte;
      sdaLow <= ~rdByte[7];
    end else if (strb.txShift) begin
      txReg  <= {txReg[6:0], 1'b0};
      sdaLow <= ~txReg[6];
    end
  end

  // R9
  drive_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !$past(sclLvl));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.latchLo) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && ptr == '1) |=> (ptr == '0));

endmodule

// File: rtl/eeprom_read_target.sv
module eeprom_read_target
  import eeprd_pkg::*;
#(
  parameter int         ADDR_W       = 12,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_CODE     = 4'b1010,
  parameter logic [7:0] PRELOAD_SEED = 8'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapSel,
  output logic       sdaDriveLow
);

  logic    sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  strobe_t strb;
  state_t  ctrlState;

  eeprd_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  eeprd_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .strapSel(strapSel), .strb(strb), .stateOut(ctrlState)
  );

  eeprd_dpath #(.ADDR_W(ADDR_W), .PRELOAD_SEED(PRELOAD_SEED)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl), .sclLvl(sclLvl),
    .rxByte(rxByte), .sdaLow(sdaDriveLow)
  );

  // R3
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IGN || ctrlState == ST_IDLE) |-> !sdaDriveLow);

endmodule

// File: tb/eeprom_read_target_bench.sv
module eeprom_read_target_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       drv;
  wire        sdaLine = sdaM & ~drv;

  eeprom_read_target u_eeprom_read_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapSel(strap), .sdaDriveLow(drv)
  );

  int checks = 0;
  int fails  = 0;
  int refPtr = 0;
  bit done   = 0;

  function automatic int refByte(int a);
    return ((a & 255) ^ (((a >> 8) & 15) * 17) ^ 'h5A) & 255;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: per-clock watch on the drive while the bus clock stays high
  logic pScl = 1'b1;
  logic pDrv = 1'b0;
  always @(negedge clk) begin
    if (rstN && pScl && sclM) begin
      checks++;
      if (drv !== pDrv) begin
        fails++;
        $display("FAIL R9 actual=%0h expected=%0h", drv, pDrv);
      end
    end
    pScl <= sclM;
    pDrv <= drv;
  end

  task automatic q;
    repeat (10) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; q; sclM = 1'b1; q; sdaM = 1'b0; q; sclM = 1'b0; q;
  endtask

  task automatic busStop;
    sdaM = 1'b0; q; sclM = 1'b1; q; sdaM = 1'b1; q;
  endtask

  task automatic wbit(input bit b);
    sdaM = b; q; sclM = 1'b1; q; q; sclM = 1'b0; q;
  endtask

  task automatic rbit(output bit b);
    sdaM = 1'b1; q; sclM = 1'b1; q; b = sdaLine; q; sclM = 1'b0; q;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit nack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(nack);
  endtask

  task automatic recvByte(output logic [7:0] v, input bit giveAck);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(!giveAck);
  endtask

  task automatic readRun(input int n, input string tag);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recvByte(v, i < n - 1);
      chk(v == refByte(refPtr), tag, v, refByte(refPtr));
      refPtr = (refPtr + 1) & 4095;
    end
    busStop;
    q;
    chk(drv == 1'b0, "R8", drv, 0);
  endtask

  task automatic curRead(input int n, input string tag);
    bit nack;
    busStart;
    sendByte({4'b1010, strap, 1'b1}, nack);
    chk(nack == 1'b0, "R2", nack, 0);
    readRun(n, tag);
  endtask

  task automatic randRead(input int addr, input logic [3:0] junk, input int n, input string tag);
    bit nack;
    busStart;
    sendByte({4'b1010, strap, 1'b0}, nack);
    chk(nack == 1'b0, "R2", nack, 0);
    sendByte({junk, 4'(addr >> 8)}, nack);
    chk(nack == 1'b0, "R5", nack, 0);
    sendByte(8'(addr), nack);
    chk(nack == 1'b0, "R5", nack, 0);
    busStart;
    sendByte({4'b1010, strap, 1'b1}, nack);
    chk(nack == 1'b0, "R2", nack, 0);
    refPtr = addr;
    readRun(n, tag);
  endtask

  task automatic badSelect(input logic [7:0] ctl);
    bit nack;
    logic [7:0] v;
    busStart;
    sendByte(ctl, nack);
    chk(nack == 1'b1, "R3", nack, 1);
    recvByte(v, 1'b0);
    chk(v == 8'hFF, "R3", v, 8'hFF);
    busStop;
  endtask

  initial begin
    bit nack;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    q;
    chk(drv == 1'b0, "R1", drv, 0);
    // R1 R4 R10: reset pointer and preload pattern
    curRead(1, "R1");
    curRead(2, "R6");
    // R5: upper nibble of the high location byte is junk
    randRead('h234, 4'hF, 1, "R5");
    curRead(1, "R8");
    // R7: streamed read over the top of the array
    randRead('hFFD, 4'h0, 5, "R7");
    curRead(1, "R4");
    // R3: wrong chip-select, then wrong device nibble
    badSelect({4'b1010, 3'b011, 1'b1});
    badSelect({4'b1011, strap, 1'b1});
    curRead(1, "R3");
    // R11: Start inside a location byte
    busStart;
    sendByte({4'b1010, strap, 1'b0}, nack);
    chk(nack == 1'b0, "R2", nack, 0);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    busStart;
    sendByte({4'b1010, strap, 1'b1}, nack);
    chk(nack == 1'b0, "R11", nack, 0);
    readRun(1, "R11");
    // R11: Stop inside a control byte
    busStart;
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    busStop;
    curRead(1, "R11");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule